// File: doc/BRIEF.md
# Inter-Processor Destination Matcher

This block decides which of a set of cores takes an inter-processor message sent by one of them. Each cycle the sending side can present a request: a destination byte, a physical/logical mode bit, a two-bit shorthand, a three-bit delivery mode and the index of the sending core. Every core supplies its 8-bit physical ID, its 8-bit logical ID, the 4-bit model nibble of its format register and an enable flag. One cycle later the block gives a registered accept vector with one bit per core.

Logical addressing has two models. In the flat model the logical ID is a bitmask. In the cluster model the upper nibble names a cluster and the lower nibble is a mask within it. A shorthand overrides the address entirely. With the lowest-priority delivery mode only one core takes the message. A rotating pointer picks it from among the cores that are matched and enabled, so repeated messages are spread over those cores in turn.

Top module: `ipi_dest_matcher`

## Requirements
- R1: After reset, `accept_valid` and `accept` are 0. The rotation pointer is set so that the first lowest-priority search starts at core 0.
- R2: With shorthand 0 and `dest_logical` = 0, core i matches when `dest_byte` equals its physical ID or when `dest_byte` is 8'hFF.
- R3: With shorthand 0, `dest_logical` = 1 and model nibble 4'hF (flat), core i matches when its logical ID ANDed with `dest_byte` is nonzero.
- R4: With shorthand 0, `dest_logical` = 1 and model nibble 4'h0 (cluster), core i matches when the upper nibbles of its logical ID and `dest_byte` are equal and the lower nibbles share at least one set bit.
- R5: In logical mode, a core whose model nibble is neither 4'hF nor 4'h0 matches nothing.
- R6: Shorthand 1 matches only core `src_idx`. Shorthand 2 matches every core. Shorthand 3 matches every core except `src_idx`. In all three cases `dest_byte` and `dest_logical` are ignored.
- R7: For any delivery mode other than 3'b001, `accept` equals the set of matched cores, regardless of `core_en`. It appears with `accept_valid` = 1 in the cycle after `req_valid`.
- R8: For delivery mode 3'b001 (lowest priority), `accept` is one-hot. It selects the first core that is both matched and enabled, scanning from one past the previously chosen index and wrapping from N-1 to 0. That core becomes the new previous index.
- R9: In lowest-priority mode, if no matched core is enabled, `accept` is 0 and the previous index is left unchanged.
- R10: In a cycle that follows one with `req_valid` = 0, `accept_valid` and `accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| dest_byte | input | 8 | Destination byte from the upper command word |
| dest_logical | input | 1 | 0 physical, 1 logical addressing |
| shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but source |
| deliv_mode | input | 3 | Delivery mode; 3'b001 is lowest priority |
| src_idx | input | IDX_W | Index of the sending core |
| core_phys_id | input | N*8 | Physical IDs, core i in bits 8i+7:8i |
| core_log_id | input | N*8 | Logical IDs, core i in bits 8i+7:8i |
| core_fmt | input | N*4 | Model nibbles, core i in bits 4i+3:4i |
| core_en | input | N | Core enabled flags |
| accept_valid | output | 1 | Registered: a request was evaluated |
| accept | output | N | Registered accept vector |

## Verification
The physical tests separate an exact ID hit from the 8'hFF broadcast, and both from a miss. The logical tests use distinct one-hot logical IDs, so a result that ORs instead of ANDs, or ignores the cluster nibble, shows up as a wrong set of cores. Mixed model nibbles check that an unknown model drops out. Each shorthand is sent with a destination that would select a different set, which proves the address is ignored.

Long runs of lowest-priority requests check the start at core 0, the wrap from the last core, skipping of disabled or unmatched cores, and a fully disabled set. A pick made right after that empty result shows whether the pointer moved. Idle cycles with busy inputs between requests check that nothing leaks out.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int ID_W = 8;
    localparam int FMT_W = 4;

    typedef enum logic [1:0] {
        SH_NONE    = 2'd0,
        SH_SELF    = 2'd1,
        SH_ALL     = 2'd2,
        SH_ALL_BUT = 2'd3
    } shand_e;

    localparam logic [2:0]       DM_LOWEST   = 3'b001;
    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;
    localparam logic [ID_W-1:0]  DEST_BCAST  = 8'hFF;
endpackage

// File: rtl/ipi_core_match.sv
module ipi_core_match
    import ipi_pkg::*;
(
    input  logic [ID_W-1:0]  dest,
    input  logic             dest_logical,
    input  shand_e           shorthand,
    input  logic             is_src,
    input  logic [ID_W-1:0]  phys_id,
    input  logic [ID_W-1:0]  log_id,
    input  logic [FMT_W-1:0] fmt,
    output logic             hit
);
    localparam int NIB = ID_W / 2;

    logic addr_hit;

    always_comb begin
        addr_hit = 1'b0;
        if (!dest_logical) begin
            addr_hit = (dest == phys_id) || (dest == DEST_BCAST);
        end else begin
            case (fmt)
                FMT_FLAT:    addr_hit = |(log_id & dest);
                FMT_CLUSTER: addr_hit = (log_id[ID_W-1:NIB] == dest[ID_W-1:NIB]) &&
                                        (|(log_id[NIB-1:0] & dest[NIB-1:0]));
                default:     addr_hit = 1'b0;
            endcase
        end
    end

    always_comb begin
        case (shorthand)
            SH_NONE:    hit = addr_hit;
            SH_SELF:    hit = is_src;
            SH_ALL:     hit = 1'b1;
            SH_ALL_BUT: hit = !is_src;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] ptr,
    output logic [N-1:0]     grant,
    output logic             found,
    output logic [IDX_W-1:0] grant_idx
);
    int c;

    always_comb begin
        grant     = '0;
        found     = 1'b0;
        grant_idx = ptr;
        c         = 0;
        for (int k = 1; k <= N; k++) begin
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!found && cand[c]) begin
                found     = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = c[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher
    import ipi_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         dest_byte,
    input  logic               dest_logical,
    input  logic [1:0]         shorthand,
    input  logic [2:0]         deliv_mode,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic [N*8-1:0]     core_phys_id,
    input  logic [N*8-1:0]     core_log_id,
    input  logic [N*4-1:0]     core_fmt,
    input  logic [N-1:0]       core_en,
    output logic               accept_valid,
    output logic [N-1:0]       accept
);
    localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N - 1);

    typedef struct packed {
        logic             valid;
        logic             lowest;
        logic [N-1:0]     accept;
        logic [IDX_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]     match;
    logic [N-1:0]     rr_grant;
    logic             rr_found;
    logic [IDX_W-1:0] rr_idx;

    for (genvar i = 0; i < N; i++) begin : g_core
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        ipi_core_match u_match (
            .dest         (dest_byte),
            .dest_logical (dest_logical),
            .shorthand    (shand_e'(shorthand)),
            .is_src       (src_idx == MY_IDX),
            .phys_id      (core_phys_id[i*ID_W +: ID_W]),
            .log_id       (core_log_id[i*ID_W +: ID_W]),
            .fmt          (core_fmt[i*FMT_W +: FMT_W]),
            .hit          (match[i])
        );
    end

    ipi_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .cand      (match & core_en),
        .ptr       (st_q.ptr),
        .grant     (rr_grant),
        .found     (rr_found),
        .grant_idx (rr_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = req_valid;
        st_d.lowest = req_valid && (deliv_mode == DM_LOWEST);
        st_d.accept = '0;
        if (req_valid) begin
            if (deliv_mode == DM_LOWEST) begin
                st_d.accept = rr_grant;
                if (rr_found) st_d.ptr = rr_idx;
            end else begin
                st_d.accept = match;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid  <= 1'b0;
            st_q.lowest <= 1'b0;
            st_q.accept <= '0;
            st_q.ptr    <= PTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_valid = st_q.valid;
    assign accept       = st_q.accept;

    // R7: a request always yields a result one cycle later
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> accept_valid);

    // R10: no result without a request
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_valid |-> (accept == '0));

    // R8: lowest priority picks at most one core
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_valid && st_q.lowest) |-> $onehot0(accept));

    // R8: the chosen core was enabled when the request arrived
    a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && deliv_mode == DM_LOWEST) |=> ((accept & ~$past(core_en)) == '0));

    // R9: an empty pick leaves the rotation pointer where it was
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_valid && st_q.lowest && accept == '0) |-> $stable(st_q.ptr));

    // R6: all-but-self never selects the sender
    a_r6_allbut_excludes_src: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && shorthand == 2'd3) |=> !accept[$past(src_idx)]);
endmodule

// File: tb/test_ipi_dest_matcher.sv
`timescale 1ns/1ps
module test_ipi_dest_matcher;
    localparam int NC = 8;
    localparam int IW = $clog2(NC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] dest_byte = '0;
    logic dest_logical = 1'b0;
    logic [1:0] shorthand = '0;
    logic [2:0] deliv_mode = '0;
    logic [IW-1:0] src_idx = '0;
    logic [NC*8-1:0] core_phys_id, core_log_id;
    logic [NC*4-1:0] core_fmt;
    logic [NC-1:0] core_en;
    logic accept_valid;
    logic [NC-1:0] accept;

    logic [7:0] phys [NC];
    logic [7:0] logid [NC];
    logic [3:0] fmtv [NC];
    logic [NC-1:0] en;

    int n_tests = 0;
    int n_fail  = 0;
    int rptr    = NC - 1;
    logic exp_valid = 1'b0;
    logic [NC-1:0] exp_acc = '0;
    string exp_tag = "R1";

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            core_phys_id[i*8 +: 8] = phys[i];
            core_log_id[i*8 +: 8]  = logid[i];
            core_fmt[i*4 +: 4]     = fmtv[i];
        end
        core_en = en;
    end

    ipi_dest_matcher #(.N(NC)) i_ipi_dest_matcher (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dest_byte(dest_byte),
        .dest_logical(dest_logical), .shorthand(shorthand), .deliv_mode(deliv_mode),
        .src_idx(src_idx), .core_phys_id(core_phys_id), .core_log_id(core_log_id),
        .core_fmt(core_fmt), .core_en(core_en), .accept_valid(accept_valid),
        .accept(accept)
    );

    function automatic bit ref_hit(int i, logic [7:0] d, logic lg, logic [1:0] sh, int src);
        if (sh == 2'd1) return i == src;
        if (sh == 2'd2) return 1'b1;
        if (sh == 2'd3) return i != src;
        if (!lg) return (d == phys[i]) || (d == 8'hFF);
        if (fmtv[i] == 4'hF) return (logid[i] & d) != 0;
        if (fmtv[i] == 4'h0)
            return (logid[i] >> 4) == (d >> 4) && ((logid[i] & d & 8'h0F) != 0);
        return 1'b0;
    endfunction

    task automatic check_now();
        n_tests++;
        if (accept_valid !== exp_valid || accept !== exp_acc) begin
            n_fail++;
            $display("FAIL %s: valid=%0b accept=%b expected valid=%0b accept=%b",
                     exp_tag, accept_valid, accept, exp_valid, exp_acc);
        end
    endtask

    task automatic step(logic v, logic [7:0] d, logic lg, logic [1:0] sh,
                        logic [2:0] dm, int src, string tag);
        logic [NC-1:0] m;
        @(negedge clk);
        check_now();
        req_valid = v; dest_byte = d; dest_logical = lg; shorthand = sh;
        deliv_mode = dm; src_idx = IW'(src);
        m = '0;
        for (int i = 0; i < NC; i++) m[i] = ref_hit(i, d, lg, sh, src);
        exp_valid = v;
        exp_acc = '0;
        exp_tag = tag;
        if (v) begin
            if (dm == 3'b001) begin
                for (int s = 1; s <= NC; s++) begin
                    int c;
                    c = (rptr + s) % NC;
                    if (m[c] && en[c]) begin
                        exp_acc[c] = 1'b1;
                        rptr = c;
                        break;
                    end
                end
            end else begin
                exp_acc = m;
            end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            phys[i] = 8'h10 + 8'(i); logid[i] = 8'(1 << i); fmtv[i] = 4'hF;
        end
        en = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked on the first comparison
        step(0, 8'h00, 0, 0, 0, 0, "R1");
        // R2: physical exact, broadcast, miss
        step(1, 8'h13, 0, 0, 0, 1, "R2");
        step(1, 8'hFF, 0, 0, 0, 1, "R2");
        step(1, 8'h44, 0, 0, 0, 1, "R2");
        // R10: idle with busy inputs
        step(0, 8'hFF, 0, 2, 0, 1, "R10");
        // R3: flat logical
        step(1, 8'h05, 1, 0, 0, 0, "R3");
        step(1, 8'hA0, 1, 0, 0, 0, "R3");
        // R4: cluster logical
        for (int i = 0; i < NC; i++) begin
            fmtv[i] = 4'h0; logid[i] = 8'(((i / 4) << 4) | (1 << (i % 4)));
        end
        step(1, 8'h13, 1, 0, 0, 0, "R4");
        step(1, 8'h03, 1, 0, 0, 0, "R4");
        step(1, 8'h20, 1, 0, 0, 0, "R4");
        step(1, 8'h10, 1, 0, 0, 0, "R4");
        // R5: unknown model nibble
        fmtv[1] = 4'h5; fmtv[5] = 4'h7;
        step(1, 8'h0F, 1, 0, 0, 0, "R5");
        step(1, 8'h1F, 1, 0, 0, 0, "R5");
        for (int i = 0; i < NC; i++) begin fmtv[i] = 4'hF; logid[i] = 8'(1 << i); end
        // R6: shorthands ignore the destination
        step(1, 8'h14, 0, 1, 0, 2, "R6");
        step(1, 8'h00, 1, 2, 0, 2, "R6");
        step(1, 8'h12, 0, 3, 0, 2, "R6");
        // R7: non-lowest delivery ignores enables
        en = 8'b0000_0101;
        step(1, 8'hFF, 0, 0, 3'b100, 0, "R7");
        step(1, 8'h0F, 1, 0, 3'b000, 0, "R7");
        en = '1;
        // R8: rotation from core 0 with wrap
        for (int k = 0; k < NC + 3; k++) step(1, 8'hFF, 0, 0, 3'b001, 0, "R8");
        en = 8'b1010_0010;
        for (int k = 0; k < 5; k++) step(1, 8'hFF, 0, 2, 3'b001, 0, "R8");
        en = '1;
        for (int k = 0; k < 4; k++) step(1, 8'h99, 1, 0, 3'b001, 0, "R8");
        // R9: nothing enabled among matched, pointer held
        en = 8'b0000_1111;
        step(1, 8'hF0, 1, 0, 3'b001, 0, "R9");
        en = '1;
        step(1, 8'hFF, 0, 0, 3'b001, 0, "R9");
        step(1, 8'hFF, 0, 0, 3'b001, 0, "R9");
        step(0, 8'h00, 0, 0, 3'b001, 0, "R10");
        step(0, 8'h00, 0, 0, 0, 0, "R10");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule